// File: doc/BRIEF.md
# Indexed Indirect Register Window

This block lets a host with a tiny address space reach a large internal register file. The host sees four direct locations. Two of them hold the bytes of a 16-bit index. The third is a data location: a write there becomes an internal register write at the indexed address, and a read there becomes an internal register read. The fourth location returns a status byte that says whether the command buffer can take a new command.

Bit 14 of the index selects a paired write mode. In that mode one host write to the data location carries 16 bits and updates two neighbouring internal registers in the same cycle. The low byte goes to the indexed address and the high byte to the next address. Bit 15 of the index is reserved and has no effect. The internal address is 14 bits wide. Index writes never touch the internal register file. Reads return data one cycle after the request.

Top module: `idx_reg_port`

## Requirements
- R1: After reset both index bytes are zero, so `reg_addr` is 0. No internal strobe is active and `host_rvalid` is low.
- R2: A host write to location 0 loads index bits 7:0, and a write to location 1 loads index bits 15:8. The new index shows on `reg_addr` from the next cycle. Index writes raise no internal strobe.
- R3: A host write to location 2 with index bit 14 clear raises `reg_we` in the same cycle. `reg_addr` carries index bits 13:0 and `reg_wdata` carries `host_wdata[7:0]`. `reg_we_hi` stays low.
- R4: A host write to location 2 with index bit 14 set raises both `reg_we` and `reg_we_hi` in the same cycle. `reg_wdata` carries `host_wdata[7:0]` to `reg_addr`. `reg_wdata_hi` carries `host_wdata[15:8]` to `reg_addr_hi`, which equals `reg_addr` + 1.
- R5: In paired mode, `reg_addr_hi` wraps within 14 bits: an index of 0x3FFF gives `reg_addr_hi` = 0.
- R6: A host read of location 2 raises `reg_re` in the same cycle. One cycle later `host_rdata` holds the `reg_rdata` value seen at the request, and `host_rvalid` is high for exactly that cycle.
- R7: A host read of location 3 returns, one cycle later, bit 0 equal to `cmd_ready` at the request and bits 7:1 equal to zero.
- R8: Index bit 15 is ignored. It changes neither `reg_addr` nor the write mode.
- R9: Host reads of locations 0 and 1 return 0x00 with `host_rvalid`. Host writes to location 3 have no effect. Neither kind of access raises an internal strobe.
- R10: With `host_en` low, no internal strobe is raised, the index does not change and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access in this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_loc | input | 2 | Direct location: 0 index low, 1 index high, 2 data, 3 status |
| host_wdata | input | 16 | Write data; upper byte used only in paired mode |
| host_rdata | output | 8 | Read data, one cycle after the read |
| host_rvalid | output | 1 | Marks `host_rdata` valid |
| cmd_ready | input | 1 | Command buffer can accept a command |
| reg_addr | output | 14 | Internal address of the primary access |
| reg_re | output | 1 | Internal read strobe |
| reg_rdata | input | 8 | Internal read data for `reg_addr` |
| reg_we | output | 1 | Internal write strobe, primary byte |
| reg_wdata | output | 8 | Primary write byte |
| reg_addr_hi | output | 14 | Internal address of the paired byte |
| reg_we_hi | output | 1 | Internal write strobe, paired byte |
| reg_wdata_hi | output | 8 | Paired write byte |

## Verification
Internal strobes, addresses and write data are due in the same cycle as the host access. The bench samples them a short delay after it drives the inputs, before the next clock edge. An index write takes effect on `reg_addr` only after the clock edge that captures it, so the bench checks the index at the following sample point. Read data is due one cycle after the request. The driver queues each expected byte and the monitor compares it at the next falling edge where `host_rvalid` is high, so one expected item is consumed per valid cycle.

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_wr,
  input  logic [1:0]        host_loc,
  input  logic [2*DW-1:0]   host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid,
  input  logic              cmd_ready,
  output logic [2*DW-3:0]   reg_addr,
  output logic              reg_re,
  input  logic [DW-1:0]     reg_rdata,
  output logic              reg_we,
  output logic [DW-1:0]     reg_wdata,
  output logic [2*DW-3:0]   reg_addr_hi,
  output logic              reg_we_hi,
  output logic [DW-1:0]     reg_wdata_hi
);
  localparam int IW       = 2 * DW;
  localparam int AW       = IW - 2;
  localparam int PAIR_BIT = IW - 2;

  localparam logic [1:0] LOC_LO   = 2'd0;
  localparam logic [1:0] LOC_HI   = 2'd1;
  localparam logic [1:0] LOC_DATA = 2'd2;
  localparam logic [1:0] LOC_STAT = 2'd3;

  logic [DW-1:0] idx_lo, idx_hi;
  logic [IW-1:0] index;
  logic          pair_mode;
  logic          wr_cyc, rd_cyc;

  assign index     = {idx_hi, idx_lo};
  assign pair_mode = index[PAIR_BIT];
  assign wr_cyc    = host_en && host_wr;
  assign rd_cyc    = host_en && !host_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_lo <= '0;
      idx_hi <= '0;
    end else if (wr_cyc) begin
      if (host_loc == LOC_LO) idx_lo <= host_wdata[DW-1:0];
      if (host_loc == LOC_HI) idx_hi <= host_wdata[DW-1:0];
    end
  end

  assign reg_addr     = index[AW-1:0];
  assign reg_addr_hi  = reg_addr + 1'b1;
  assign reg_we       = wr_cyc && host_loc == LOC_DATA;
  assign reg_we_hi    = reg_we && pair_mode;
  assign reg_wdata    = host_wdata[DW-1:0];
  assign reg_wdata_hi = host_wdata[IW-1:DW];
  assign reg_re       = rd_cyc && host_loc == LOC_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_cyc;
      if (rd_cyc) begin
        case (host_loc)
          LOC_DATA: host_rdata <= reg_rdata;
          LOC_STAT: host_rdata <= {{(DW-1){1'b0}}, cmd_ready};
          default:  host_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/idx_reg_port_checker.sv
module idx_reg_port_checker #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_en,
  input logic            host_wr,
  input logic [1:0]      host_loc,
  input logic [DW-1:0]   host_rdata,
  input logic            host_rvalid,
  input logic            cmd_ready,
  input logic [2*DW-3:0] reg_addr,
  input logic            reg_re,
  input logic [DW-1:0]   reg_rdata,
  input logic            reg_we,
  input logic [2*DW-3:0] reg_addr_hi,
  input logic            reg_we_hi
);
  a_r6_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_wr) |=> host_rvalid);

  a_r10_no_rvalid_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && !host_wr) |=> !host_rvalid);

  a_r6_rdata_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_wr && host_loc == 2'd2) |=> host_rdata == $past(reg_rdata));

  a_r7_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_wr && host_loc == 2'd3) |=> host_rdata == {{(DW-1){1'b0}}, $past(cmd_ready)});

  a_r4_pair_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_hi |-> (reg_we && reg_addr_hi == reg_addr + 1'b1));

  a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_en && host_wr && host_loc[1] == 1'b0) |=> $stable(reg_addr));

  a_r9_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
endmodule

bind idx_reg_port idx_reg_port_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
  .host_loc(host_loc), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .cmd_ready(cmd_ready), .reg_addr(reg_addr), .reg_re(reg_re),
  .reg_rdata(reg_rdata), .reg_we(reg_we), .reg_addr_hi(reg_addr_hi),
  .reg_we_hi(reg_we_hi)
);

// File: tb/idx_reg_port_test.sv
module idx_reg_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_loc = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        cmd_ready = 1'b0;
  logic [13:0] reg_addr, reg_addr_hi;
  logic        reg_re, reg_we, reg_we_hi;
  logic [7:0]  reg_rdata, reg_wdata, reg_wdata_hi;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign reg_rdata = reg_addr[7:0] ^ reg_addr[13:8] ^ 8'h5A;

  idx_reg_port uut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_wr(host_wr),
    .host_loc(host_loc), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .cmd_ready(cmd_ready), .reg_addr(reg_addr),
    .reg_re(reg_re), .reg_rdata(reg_rdata), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_addr_hi(reg_addr_hi), .reg_we_hi(reg_we_hi),
    .reg_wdata_hi(reg_wdata_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [13:0] a);
    return a[7:0] ^ {2'b0, a[13:8]} ^ 8'h5A;
  endfunction

  task automatic drive(input logic en, input logic wr, input logic [1:0] loc, input logic [15:0] d);
    @(negedge clk);
    host_en = en; host_wr = wr; host_loc = loc; host_wdata = d;
    #1;
  endtask

  task automatic release_bus;
    @(posedge clk);
    #1 host_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] loc, input logic [7:0] exp);
    drive(1'b1, 1'b0, loc, 16'h0);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    release_bus();
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) chk("R10 unexpected rvalid", 1, 0);
      else chk(tag_q.pop_front(), {24'h0, host_rdata}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr", reg_addr, 0);
    chk("R1 rvalid", host_rvalid, 0);
    chk("R1 strobes", {reg_we, reg_we_hi, reg_re}, 0);
    rst_n = 1'b1;

    drive(1, 1, 2'd0, 16'h0034);
    chk("R2 no strobe on index write", {reg_we, reg_we_hi, reg_re}, 0);
    release_bus();
    drive(1, 1, 2'd1, 16'h0012);
    release_bus();
    #1 chk("R2 index", reg_addr, 14'h1234);

    drive(1, 1, 2'd2, 16'hBEA5);
    chk("R3 we", {reg_we, reg_we_hi}, 2'b10);
    chk("R3 addr", reg_addr, 14'h1234);
    chk("R3 wdata", reg_wdata, 8'hA5);
    release_bus();

    drive(1, 0, 2'd2, 16'h0);
    chk("R6 re", reg_re, 1);
    exp_q.push_back(model_rd(14'h1234)); tag_q.push_back("R6 rdata");
    release_bus();
    rd("R6 back-to-back rdata", 2'd2, model_rd(14'h1234));

    cmd_ready = 1'b1;
    rd("R7 status ready", 2'd3, 8'h01);
    cmd_ready = 1'b0;
    rd("R7 status busy", 2'd3, 8'h00);

    drive(1, 0, 2'd0, 16'h0);
    chk("R9 no strobe on loc0 read", {reg_we, reg_re}, 0);
    exp_q.push_back(8'h00); tag_q.push_back("R9 loc0 read");
    release_bus();
    rd("R9 loc1 read", 2'd1, 8'h00);
    drive(1, 1, 2'd3, 16'hFFFF);
    chk("R9 no strobe on loc3 write", {reg_we, reg_we_hi, reg_re}, 0);
    release_bus();
    #1 chk("R9 index unchanged", reg_addr, 14'h1234);

    drive(1, 1, 2'd1, 16'h0045);
    release_bus();
    drive(1, 1, 2'd2, 16'hC3D4);
    chk("R4 both strobes", {reg_we, reg_we_hi}, 2'b11);
    chk("R4 addr", reg_addr, 14'h0534);
    chk("R4 addr hi", reg_addr_hi, 14'h0535);
    chk("R4 data", {reg_wdata_hi, reg_wdata}, 16'hC3D4);
    release_bus();

    drive(1, 1, 2'd1, 16'h007F);
    release_bus();
    drive(1, 1, 2'd0, 16'h00FF);
    release_bus();
    drive(1, 1, 2'd2, 16'h1122);
    chk("R5 addr", reg_addr, 14'h3FFF);
    chk("R5 wrap", reg_addr_hi, 14'h0000);
    chk("R5 we hi", reg_we_hi, 1);
    release_bus();

    drive(1, 1, 2'd1, 16'h0081);
    release_bus();
    drive(1, 1, 2'd2, 16'h7788);
    chk("R8 addr ignores bit15", reg_addr, 14'h01FF);
    chk("R8 mode ignores bit15", {reg_we, reg_we_hi}, 2'b10);
    release_bus();
    rd("R8 read at index", 2'd2, model_rd(14'h01FF));

    drive(0, 1, 2'd2, 16'h5555);
    chk("R10 no write strobe", {reg_we, reg_we_hi}, 0);
    release_bus();
    drive(0, 1, 2'd0, 16'h0000);
    release_bus();
    #1 chk("R10 index kept", reg_addr, 14'h01FF);
    drive(0, 0, 2'd2, 16'h0);
    chk("R10 no read strobe", reg_re, 0);
    release_bus();

    repeat (3) @(posedge clk);
    chk("R6 all reads returned", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule